// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler

This block holds one 8-bit prescaler that divides a tick stream before it reaches one of two 8-bit counters: a general timer/counter or a watchdog. A control byte written through `cfg_wr`/`cfg_wdata` picks the divide code, which counter owns the prescaler, and where the timer takes its ticks from. The timer's source is either the instruction-cycle enable or the alternate oscillator enable. The watchdog always counts the oscillator enable. The counter that does not own the prescaler sees its source undivided. The same 3-bit code gives the timer a ratio twice that of the watchdog. All logic runs on one system clock, and the prescaler output is a one-cycle enable, not a derived clock.

A two-state routing machine records the owner. In `ROUTE_TCC` the prescaler divides the timer source. In `ROUTE_WDT` it divides the oscillator ticks that feed the watchdog. The transition `ROUTE_TCC -> ROUTE_WDT` is taken on a control write with bit 3 set. The transition `ROUTE_WDT -> ROUTE_TCC` is taken on a control write with bit 3 clear. Any other cycle holds the state. The timer raises a one-cycle overflow flag when it wraps. The watchdog raises a one-cycle timeout pulse when it wraps. The pulse is meant for the chip's reset logic.

Top module: `shared_prescaler`

## Requirements
- R1: After reset, `tcc_count` is 0x00 and both `tcc_ovf` and `wdt_timeout` are low. The routing state is `ROUTE_TCC`, with code 000 and the instruction-cycle source.
- R2: When `cfg_wdata[3]`=0, the prescaler feeds the timer. Code `cfg_wdata[2:0]`=k divides the timer source by 2^(k+1), so 000 gives 1:2 and 111 gives 1:256.
- R3: When `cfg_wdata[3]`=1, the prescaler feeds the watchdog. Code k divides the oscillator ticks by 2^k, so 000 gives 1:1. After a clear, the timeout therefore arrives on oscillator tick 256·2^k.
- R4: The counter that does not own the prescaler advances once per tick of its own source.
- R5: `cfg_wdata[5]`=0 makes the timer source `inst_tick`, and `cfg_wdata[5]`=1 makes it `osc_tick`. Ticks on the unselected input do not move `tcc_count`.
- R6: When the timer advances from 0xFF it wraps to 0x00. `tcc_ovf` is high for exactly the one cycle in which `tcc_count` first reads 0x00.
- R7: `wdt_clear` always zeroes the watchdog counter. It zeroes the prescaler only in `ROUTE_WDT`, and in `ROUTE_TCC` it leaves a partial prescaler count intact.
- R8: Every control write zeroes the prescaler, so no partial count carries into the new setting. The timer value is kept across the write.
- R9: `wdt_timeout` is a single-cycle pulse in the cycle after the tick that wraps the watchdog from 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inst_tick | input | 1 | Instruction-cycle enable, one cycle wide |
| osc_tick | input | 1 | Alternate oscillator enable; watchdog source |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte: [2:0] code, [3] owner, [5] timer source; other bits ignored |
| wdt_clear | input | 1 | Watchdog clear strobe |
| tcc_count | output | 8 | Timer/counter value |
| tcc_ovf | output | 1 | Timer wrap flag, one cycle |
| wdt_timeout | output | 1 | Watchdog timeout pulse, one cycle |

## Verification
The bench counts ticks up to a timeout and compares the exact count, so a routing state stuck on the wrong owner shows at once. The timer would then advance on the first tick where it should hold, or the watchdog's tick count would be off by a factor of 2^k. A prescaler that was not cleared on a write or a clear strobe shows within one or two ticks as an early or missing timer step. A wrong ratio decode only shows once a full prescaler period has elapsed, which can be up to 256 source ticks. A bad wrap flag shows in the cycle the timer reads 0x00.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int PSC_W  = 8;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 8;
    localparam int CFG_W  = 8;

    localparam int CFG_CODE_LSB = 0;
    localparam int CFG_OWNER    = 3;
    localparam int CFG_SRC      = 5;

    typedef enum logic {
        ROUTE_TCC = 1'b0,
        ROUTE_WDT = 1'b1
    } route_e;

    // Terminal prescaler value for a code: 2^(k+1)-1 for the timer, 2^k-1 for the watchdog
    function automatic logic [PSC_W-1:0] psc_last(input logic [CODE_W-1:0] code,
                                                  input logic to_wdt);
        logic [PSC_W:0] span;
        int unsigned    sh;
        sh   = int'(code) + (to_wdt ? 0 : 1);
        span = {{PSC_W{1'b0}}, 1'b1} << sh;
        span = span - {{PSC_W{1'b0}}, 1'b1};
        return span[PSC_W-1:0];
    endfunction

endpackage

// File: rtl/psc_route_fsm.sv
module psc_route_fsm
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              inst_tick,
    input  logic              osc_tick,
    input  logic              wdt_clear,
    output route_e            route,
    output logic [CODE_W-1:0] code,
    output logic              tcc_src,
    output logic              psc_src,
    output logic              psc_clr
);

    route_e            state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              src_alt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROUTE_TCC: if (cfg_wr &&  cfg_wdata[CFG_OWNER]) state_d = ROUTE_WDT;
            ROUTE_WDT: if (cfg_wr && !cfg_wdata[CFG_OWNER]) state_d = ROUTE_TCC;
            default:   state_d = ROUTE_TCC;
        endcase
    end

    // state register and control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ROUTE_TCC;
            code_q    <= '0;
            src_alt_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_wr) begin
                code_q    <= cfg_wdata[CFG_CODE_LSB +: CODE_W];
                src_alt_q <= cfg_wdata[CFG_SRC];
            end
        end
    end

    // outputs per state
    always_comb begin
        tcc_src = src_alt_q ? osc_tick : inst_tick;
        unique case (state_q)
            ROUTE_TCC: begin
                psc_src = tcc_src;
                psc_clr = cfg_wr;
            end
            ROUTE_WDT: begin
                psc_src = osc_tick;
                psc_clr = cfg_wr | wdt_clear;
            end
            default: begin
                psc_src = 1'b0;
                psc_clr = 1'b1;
            end
        endcase
    end

    assign route = state_q;
    assign code  = code_q;

endmodule

// File: rtl/psc_divider.sv
module psc_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src,
    input  logic         clr,
    input  logic [W-1:0] last,
    output logic         pulse,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == last);
    assign pulse  = src & ~clr & at_end;
    assign cnt    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (src) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] value,
    output logic         wrapped
);

    logic [W-1:0] val_q;
    logic         wrap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (clr) begin
                val_q <= '0;
            end else if (inc) begin
                val_q  <= val_q + 1'b1;
                wrap_q <= &val_q;
            end
        end
    end

    assign value   = val_q;
    assign wrapped = wrap_q;

endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler
    import psc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_tick,
    input  logic             osc_tick,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             wdt_clear,
    output logic [CNT_W-1:0] tcc_count,
    output logic             tcc_ovf,
    output logic             wdt_timeout
);

    route_e            route;
    logic [CODE_W-1:0] code;
    logic              tcc_src, psc_src, psc_clr, psc_pulse;
    logic [PSC_W-1:0]  psc_last_v, psc_cnt_w;
    logic              tcc_inc, wdt_inc;
    logic [CNT_W-1:0]  wdt_value;

    psc_route_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .inst_tick (inst_tick),
        .osc_tick  (osc_tick),
        .wdt_clear (wdt_clear),
        .route     (route),
        .code      (code),
        .tcc_src   (tcc_src),
        .psc_src   (psc_src),
        .psc_clr   (psc_clr)
    );

    assign psc_last_v = psc_last(code, route == ROUTE_WDT);

    psc_divider #(.W(PSC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (psc_src),
        .clr   (psc_clr),
        .last  (psc_last_v),
        .pulse (psc_pulse),
        .cnt   (psc_cnt_w)
    );

    assign tcc_inc = (route == ROUTE_TCC) ? psc_pulse : tcc_src;
    assign wdt_inc = (route == ROUTE_WDT) ? psc_pulse : osc_tick;

    wrap_counter #(.W(CNT_W)) u_tcc (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tcc_inc),
        .clr     (1'b0),
        .value   (tcc_count),
        .wrapped (tcc_ovf)
    );

    wrap_counter #(.W(CNT_W)) u_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (wdt_inc),
        .clr     (wdt_clear),
        .value   (wdt_value),
        .wrapped (wdt_timeout)
    );

endmodule

// File: rtl/psc_checker.sv
module psc_checker
    import psc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             inst_tick,
    input logic             osc_tick,
    input logic             cfg_wr,
    input logic             wdt_clear,
    input logic [CNT_W-1:0] tcc_count,
    input logic             tcc_ovf,
    input logic             wdt_timeout,
    input logic [PSC_W-1:0] psc_cnt
);

    p_ovf_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tcc_ovf |-> (tcc_count == '0));

    p_ovf_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tcc_ovf |=> !tcc_ovf);

    p_timeout_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

    p_tcc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tcc_count != $past(tcc_count)) |-> (tcc_count == $past(tcc_count) + 8'd1));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inst_tick && !osc_tick) |=> $stable(tcc_count));

    p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> !wdt_timeout);

    p_write_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (psc_cnt == '0));

endmodule

bind shared_prescaler psc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inst_tick   (inst_tick),
    .osc_tick    (osc_tick),
    .cfg_wr      (cfg_wr),
    .wdt_clear   (wdt_clear),
    .tcc_count   (tcc_count),
    .tcc_ovf     (tcc_ovf),
    .wdt_timeout (wdt_timeout),
    .psc_cnt     (psc_cnt_w)
);

// File: tb/shared_prescaler_tb.sv
module shared_prescaler_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inst_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       wdt_clear = 1'b0;
    logic [7:0] tcc_count;
    logic       tcc_ovf;
    logic       wdt_timeout;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    shared_prescaler u_dut (
        .clk(clk), .rst_n(rst_n), .inst_tick(inst_tick), .osc_tick(osc_tick),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .wdt_clear(wdt_clear),
        .tcc_count(tcc_count), .tcc_ovf(tcc_ovf), .wdt_timeout(wdt_timeout)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle with the given ticks; sampled 1 ns after the edge
    task automatic step(input logic it, input logic ot);
        @(negedge clk);
        inst_tick = it;
        osc_tick  = ot;
        @(posedge clk);
        #1;
        inst_tick = 1'b0;
        osc_tick  = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        wdt_clear = 1'b1;
        @(posedge clk);
        #1;
        wdt_clear = 1'b0;
    endtask

    task automatic ticks_to_timeout(output int n);
        n = -1;
        for (int i = 0; i < 5000; i++) begin
            step(1'b0, 1'b1);
            if (wdt_timeout) begin
                n = i + 1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        check("R1 tcc_count", tcc_count, 0);
        check("R1 tcc_ovf", tcc_ovf, 0);
        check("R1 wdt_timeout", wdt_timeout, 0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        check("R1 default 1:2 on timer", tcc_count, 2);
    endtask

    task automatic t_tcc_ratios();
        int b;
        write_cfg(8'h00);
        b = tcc_count;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        check("R2 code0 1:2", tcc_count, b + 5);
        write_cfg(8'h03);
        b = tcc_count;
        for (int i = 0; i < 32; i++) step(1'b1, 1'b0);
        check("R2 code3 1:16", tcc_count, b + 2);
        write_cfg(8'h07);
        b = tcc_count;
        for (int i = 0; i < 255; i++) step(1'b1, 1'b0);
        check("R2 code7 before 256", tcc_count, b);
        step(1'b1, 1'b0);
        check("R2 code7 at 256", tcc_count, (b + 1) % 256);
    endtask

    task automatic t_wdt_ratios();
        int n;
        write_cfg(8'h08);
        pulse_clear();
        ticks_to_timeout(n);
        check("R3 code0 1:1", n, 256);
        write_cfg(8'h09);
        pulse_clear();
        ticks_to_timeout(n);
        check("R3 code1 1:2", n, 512);
        write_cfg(8'h0A);
        pulse_clear();
        ticks_to_timeout(n);
        check("R3 code2 1:4", n, 1024);
        step(1'b0, 1'b0);
        check("R9 timeout one cycle", wdt_timeout, 0);
    endtask

    task automatic t_unassigned();
        int b, n;
        write_cfg(8'h0F);
        b = tcc_count;
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        check("R4 timer 1:1 when WDT owns", tcc_count, (b + 7) % 256);
        write_cfg(8'h07);
        pulse_clear();
        ticks_to_timeout(n);
        check("R4 watchdog 1:1 when timer owns", n, 256);
    endtask

    task automatic t_source();
        int b;
        write_cfg(8'h28);
        b = tcc_count;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        check("R5 inst ignored on alt source", tcc_count, b);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
        check("R5 osc counted on alt source", tcc_count, (b + 5) % 256);
        write_cfg(8'h08);
        b = tcc_count;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        check("R5 osc ignored on inst source", tcc_count, b);
    endtask

    task automatic t_overflow();
        int b;
        write_cfg(8'h08);
        b = tcc_count;
        for (int i = 0; i < 255 - b; i++) step(1'b1, 1'b0);
        check("R6 at 0xFF", tcc_count, 255);
        check("R6 no flag at 0xFF", tcc_ovf, 0);
        step(1'b1, 1'b0);
        check("R6 wrapped to 0", tcc_count, 0);
        check("R6 flag set", tcc_ovf, 1);
        step(1'b0, 1'b0);
        check("R6 flag one cycle", tcc_ovf, 0);
    endtask

    task automatic t_clear();
        int b, n;
        write_cfg(8'h09);
        pulse_clear();
        for (int i = 0; i < 301; i++) step(1'b0, 1'b1);
        pulse_clear();
        ticks_to_timeout(n);
        check("R7 clear resets watchdog and prescaler", n, 512);
        write_cfg(8'h00);
        b = tcc_count;
        step(1'b1, 1'b0);
        pulse_clear();
        step(1'b1, 1'b0);
        check("R7 clear keeps timer prescaler", tcc_count, (b + 1) % 256);
    endtask

    task automatic t_write_flush();
        int b;
        write_cfg(8'h00);
        b = tcc_count;
        step(1'b1, 1'b0);
        write_cfg(8'h00);
        check("R8 timer kept over write", tcc_count, b);
        step(1'b1, 1'b0);
        check("R8 partial count dropped", tcc_count, b);
        step(1'b1, 1'b0);
        check("R8 fresh period", tcc_count, (b + 1) % 256);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_tcc_ratios();
        t_wdt_ratios();
        t_unassigned();
        t_source();
        t_overflow();
        t_clear();
        t_write_flush();
        done = 1;
    end

    initial begin
        wait (done || cycles >= 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule